// File: doc/BRIEF.md
# CSR Access Gate

This block decides, in the same cycle, whether an instruction touching a control and status register may go ahead. It takes the 12-bit register address and a handful of machine-state inputs. From these it returns one of three outcomes: proceed, raise an illegal-instruction exception, or raise a virtual-instruction exception. The machine-state inputs are the current register width mode, the presence of the floating-point and vector extensions, the floating-point enable state, a debugger-access flag, the virtualization flag and the hypervisor counter-enable mask.

The gate sorts each address into a class and then applies that class's rule. The classes are:
- floating-point registers, with the combined floating-point control word as a special member;
- vector registers;
- low user counter words;
- high user counter words, which exist only in 32-bit mode;
- machine registers that exist only in 32-bit mode;
- hypervisor registers that exist only in 32-bit mode.

Any other address is refused. The decode stage sits in front of the register data path, which is outside this block, and it traps on any result other than proceed.

Top module: `csr_gate`

## Requirements
- R1: An access to the combined floating-point control word (address 0x003) gives result 2'b00 whenever `ext_v` is 1, whatever `fp_live`, `ext_f` and `dbg_req` are.
- R2: The other floating-point registers (0x001, 0x002) always follow this rule, and 0x003 follows it when `ext_v` is 0. The result is 2'b00 when `dbg_req` is 1 or when both `ext_f` and `fp_live` are 1, and 2'b01 otherwise.
- R3: The vector registers are 0x008, 0x009, 0x00A, 0x00F, 0xC20, 0xC21 and 0xC22. They give 2'b00 when `ext_v` is 1 and 2'b01 when it is 0.
- R4: A low counter word at 0xC00 to 0xC1F selects counter index addr[4:0]. It gives 2'b10 when `virt_on` is 1 and bit index of `guest_ctr_en` is 0, and 2'b00 otherwise.
- R5: A high counter word at 0xC80 to 0xC9F gives 2'b01 whenever `xlen_mode` is not 2'd1 (the 32-bit mode), regardless of `virt_on` and `guest_ctr_en`.
- R6: In 32-bit mode, a high counter word applies the rule of R4 using counter index addr[4:0].
- R7: The machine register 0x310, which exists only in 32-bit mode, gives 2'b00 in 32-bit mode and 2'b01 in any other mode.
- R8: The hypervisor registers 0x615 and 0x61A, which exist only in 32-bit mode, give 2'b00 in 32-bit mode. In any other mode they give 2'b01, whether `virt_on` is 0 or 1.
- R9: Any address outside the classes above gives 2'b01.
- R10: The result encoding is 2'b00 for proceed, 2'b01 for illegal instruction and 2'b10 for virtual instruction. The value 2'b11 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| csr_addr | input | 12 | Register address of the access |
| xlen_mode | input | 2 | Width mode: 1 = 32-bit, 2 = 64-bit, 3 = 128-bit |
| ext_f | input | 1 | Floating-point extension present |
| ext_v | input | 1 | Vector extension present |
| fp_live | input | 1 | Floating-point unit currently enabled |
| dbg_req | input | 1 | Access comes from the debugger |
| virt_on | input | 1 | Hart is running virtualized |
| guest_ctr_en | input | 32 | Hypervisor counter-enable mask, one bit per counter |
| result | output | 2 | 00 proceed, 01 illegal instruction, 10 virtual instruction |

## Verification
The bench probes the loosened rule on the combined floating-point word. It checks that this rule does not spread to the neighbouring flag and rounding registers. A gate that applied the vector-presence exception to the whole floating-point class would let 0x001 through with the unit disabled.

The bench also checks the high counter words in 64-bit and 128-bit modes with every enable bit set. A design that tested the enable mask before the mode would wrongly return proceed there.

Counter index 31 is tried with only its neighbour enabled, to catch an off-by-one in the index select. The bench also covers the 32-bit-only hypervisor registers with virtualization both on and off, and addresses one step past each recognised range, which must be refused.

// File: rtl/csr_gate_pkg.sv
package csr_gate_pkg;

    typedef enum logic [1:0] {
        RES_NONE    = 2'b00,
        RES_ILLEGAL = 2'b01,
        RES_VIRTUAL = 2'b10
    } res_e;

    typedef enum logic [2:0] {
        CLS_UNKNOWN,
        CLS_FP,
        CLS_FCSR,
        CLS_VEC,
        CLS_CTR_LO,
        CLS_CTR_HI,
        CLS_ONLY32,
        CLS_HYP32
    } cls_e;

    localparam int unsigned ADDR_W   = 12;
    localparam logic [1:0]  MODE_32  = 2'd1;

    localparam logic [11:0] A_FFLAGS = 12'h001;
    localparam logic [11:0] A_FRM    = 12'h002;
    localparam logic [11:0] A_FCSR   = 12'h003;
    localparam logic [11:0] A_VSTART = 12'h008;
    localparam logic [11:0] A_VXSAT  = 12'h009;
    localparam logic [11:0] A_VXRM   = 12'h00A;
    localparam logic [11:0] A_VCSR   = 12'h00F;
    localparam logic [11:0] A_VL     = 12'hC20;
    localparam logic [11:0] A_VTYPE  = 12'hC21;
    localparam logic [11:0] A_VLENB  = 12'hC22;
    localparam logic [6:0]  CTR_LO_BASE = 7'h60;
    localparam logic [6:0]  CTR_HI_BASE = 7'h64;
    localparam logic [11:0] A_MSTAT_HI  = 12'h310;
    localparam logic [11:0] A_HTDELTA_HI = 12'h615;
    localparam logic [11:0] A_HENV_HI   = 12'h61A;

endpackage

// File: rtl/csr_class_decode.sv
module csr_class_decode
    import csr_gate_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output cls_e              cls
);

    always_comb begin
        cls = CLS_UNKNOWN;
        unique case (addr)
            A_FFLAGS, A_FRM:                  cls = CLS_FP;
            A_FCSR:                           cls = CLS_FCSR;
            A_VSTART, A_VXSAT, A_VXRM, A_VCSR,
            A_VL, A_VTYPE, A_VLENB:           cls = CLS_VEC;
            A_MSTAT_HI:                       cls = CLS_ONLY32;
            A_HTDELTA_HI, A_HENV_HI:          cls = CLS_HYP32;
            default: begin
                if (addr[11:5] == CTR_LO_BASE)
                    cls = CLS_CTR_LO;
                else if (addr[11:5] == CTR_HI_BASE)
                    cls = CLS_CTR_HI;
                else
                    cls = CLS_UNKNOWN;
            end
        endcase
    end

endmodule

// File: rtl/csr_ctr_gate.sv
module csr_ctr_gate
    import csr_gate_pkg::*;
#(
    parameter int unsigned NUM_CTR = 32,
    localparam int unsigned IDX_W  = $clog2(NUM_CTR)
)(
    input  logic [NUM_CTR-1:0] en_mask,
    input  logic [IDX_W-1:0]   idx,
    input  logic               virt,
    input  logic               high_half,
    input  logic               is32,
    output res_e               res
);

    logic [NUM_CTR-1:0] hit;
    logic               granted;

    for (genvar g = 0; g < NUM_CTR; g++) begin : g_sel
        assign hit[g] = (idx == IDX_W'(g)) & en_mask[g];
    end
    assign granted = |hit;

    always_comb begin
        if (high_half && !is32)
            res = RES_ILLEGAL;
        else if (virt && !granted)
            res = RES_VIRTUAL;
        else
            res = RES_NONE;
    end

endmodule

// File: rtl/csr_ext_gate.sv
module csr_ext_gate
    import csr_gate_pkg::*;
(
    input  cls_e cls,
    input  logic has_f,
    input  logic has_v,
    input  logic fp_on,
    input  logic dbg,
    output res_e res
);

    logic fp_ok;
    assign fp_ok = dbg | (has_f & fp_on);

    always_comb begin
        unique case (cls)
            CLS_FCSR: res = (has_v || fp_ok) ? RES_NONE : RES_ILLEGAL;
            CLS_FP:   res = fp_ok ? RES_NONE : RES_ILLEGAL;
            CLS_VEC:  res = has_v ? RES_NONE : RES_ILLEGAL;
            default:  res = RES_ILLEGAL;
        endcase
    end

endmodule

// File: rtl/csr_gate.sv
module csr_gate
    import csr_gate_pkg::*;
#(
    parameter int unsigned NUM_CTR = 32,
    localparam int unsigned IDX_W  = $clog2(NUM_CTR)
)(
    input  logic [11:0]        csr_addr,
    input  logic [1:0]         xlen_mode,
    input  logic               ext_f,
    input  logic               ext_v,
    input  logic               fp_live,
    input  logic               dbg_req,
    input  logic               virt_on,
    input  logic [NUM_CTR-1:0] guest_ctr_en,
    output logic [1:0]         result
);

    cls_e cls;
    res_e ext_res;
    res_e ctr_res;
    res_e final_res;
    logic is32;

    assign is32 = (xlen_mode == MODE_32);

    csr_class_decode u_dec (
        .addr (csr_addr),
        .cls  (cls)
    );

    csr_ext_gate u_ext (
        .cls   (cls),
        .has_f (ext_f),
        .has_v (ext_v),
        .fp_on (fp_live),
        .dbg   (dbg_req),
        .res   (ext_res)
    );

    csr_ctr_gate #(.NUM_CTR(NUM_CTR)) u_ctr (
        .en_mask   (guest_ctr_en),
        .idx       (csr_addr[IDX_W-1:0]),
        .virt      (virt_on),
        .high_half (cls == CLS_CTR_HI),
        .is32      (is32),
        .res       (ctr_res)
    );

    always_comb begin
        unique case (cls)
            CLS_FP, CLS_FCSR, CLS_VEC: final_res = ext_res;
            CLS_CTR_LO, CLS_CTR_HI:    final_res = ctr_res;
            CLS_ONLY32, CLS_HYP32:     final_res = is32 ? RES_NONE : RES_ILLEGAL;
            default:                   final_res = RES_ILLEGAL;
        endcase
    end

    assign result = final_res;

endmodule

// File: rtl/csr_gate_chk.sv
module csr_gate_chk (
    input logic [11:0] csr_addr,
    input logic [1:0]  xlen_mode,
    input logic        ext_v,
    input logic [1:0]  result
);

    always_comb begin
        if (!$isunknown({csr_addr, xlen_mode, ext_v, result})) begin
            // R1
            assert_fcsr_loose_R1: assert (!(csr_addr == 12'h003 && ext_v) || result == 2'b00);
            // R3
            assert_vec_absent_R3: assert (!((csr_addr == 12'hC20 || csr_addr == 12'h008) && !ext_v)
                                          || result == 2'b01);
            // R5
            assert_hi_ctr_wide_R5: assert (!(csr_addr[11:5] == 7'h64 && xlen_mode != 2'd1)
                                           || result == 2'b01);
            // R8
            assert_hyp32_wide_R8: assert (!((csr_addr == 12'h615 || csr_addr == 12'h61A)
                                            && xlen_mode != 2'd1) || result == 2'b01);
            // R9
            assert_unknown_addr_R9: assert (!(csr_addr[11:8] == 4'h7) || result == 2'b01);
            // R10
            assert_no_code3_R10: assert (result != 2'b11);
        end
    end

endmodule

bind csr_gate csr_gate_chk u_chk (
    .csr_addr  (csr_addr),
    .xlen_mode (xlen_mode),
    .ext_v     (ext_v),
    .result    (result)
);

// File: tb/sim_csr_gate.sv
module sim_csr_gate;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] csr_addr = '0;
    logic [1:0]  xlen_mode = 2'd1;
    logic        ext_f = 1'b0;
    logic        ext_v = 1'b0;
    logic        fp_live = 1'b0;
    logic        dbg_req = 1'b0;
    logic        virt_on = 1'b0;
    logic [31:0] guest_ctr_en = '0;
    logic [1:0]  result;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    csr_gate u0 (
        .csr_addr     (csr_addr),
        .xlen_mode    (xlen_mode),
        .ext_f        (ext_f),
        .ext_v        (ext_v),
        .fp_live      (fp_live),
        .dbg_req      (dbg_req),
        .virt_on      (virt_on),
        .guest_ctr_en (guest_ctr_en),
        .result       (result)
    );

    task automatic probe(input logic [11:0] a, input logic [1:0] exp, input string req);
        csr_addr = a;
        @(negedge clk);
        n_checks++;
        if (result !== exp || result === 2'b11) begin
            n_fail++;
            $display("FAIL %s addr=%h actual=%b expected=%b", req, a, result, exp);
        end
    endtask

    task automatic set_state(input logic [1:0] m, input logic f, input logic v,
                             input logic fl, input logic d, input logic vi,
                             input logic [31:0] en);
        xlen_mode = m; ext_f = f; ext_v = v; fp_live = fl;
        dbg_req = d; virt_on = vi; guest_ctr_en = en;
    endtask

    task automatic t_idle;
        set_state(2'd1, 0, 0, 0, 0, 0, 32'h0);
        probe(12'h000, 2'b01, "R9 idle");
    endtask

    task automatic t_fcsr_loose;
        set_state(2'd2, 0, 1, 0, 0, 0, 32'h0);
        probe(12'h003, 2'b00, "R1 fcsr with vector");
        probe(12'h001, 2'b01, "R2 fflags not loosened");
        probe(12'h002, 2'b01, "R2 frm not loosened");
    endtask

    task automatic t_fp;
        set_state(2'd2, 1, 0, 1, 0, 0, 32'h0);
        probe(12'h001, 2'b00, "R2 fp enabled");
        set_state(2'd2, 1, 0, 0, 1, 0, 32'h0);
        probe(12'h002, 2'b00, "R2 debugger");
        set_state(2'd2, 1, 0, 0, 0, 0, 32'h0);
        probe(12'h003, 2'b01, "R2 fp off");
        set_state(2'd2, 0, 0, 1, 0, 0, 32'h0);
        probe(12'h001, 2'b01, "R2 no F ext");
    endtask

    task automatic t_vec;
        set_state(2'd2, 0, 1, 0, 0, 0, 32'h0);
        probe(12'hC20, 2'b00, "R3 vl present");
        probe(12'h008, 2'b00, "R3 vstart present");
        set_state(2'd2, 0, 0, 0, 0, 0, 32'h0);
        probe(12'hC21, 2'b01, "R3 vtype absent");
        probe(12'h00F, 2'b01, "R3 vcsr absent");
    endtask

    task automatic t_ctr_lo;
        set_state(2'd2, 0, 0, 0, 0, 0, 32'h0);
        probe(12'hC00, 2'b00, "R4 no virt");
        set_state(2'd2, 0, 0, 0, 0, 1, 32'h0);
        probe(12'hC02, 2'b10, "R4 R10 virt bit clear");
        set_state(2'd2, 0, 0, 0, 0, 1, 32'h0000_0004);
        probe(12'hC02, 2'b00, "R4 virt bit set");
        set_state(2'd2, 0, 0, 0, 0, 1, 32'h8000_0000);
        probe(12'hC1F, 2'b00, "R4 index 31 set");
        set_state(2'd2, 0, 0, 0, 0, 1, 32'h4000_0000);
        probe(12'hC1F, 2'b10, "R4 index 31 neighbour only");
    endtask

    task automatic t_ctr_hi;
        set_state(2'd2, 0, 0, 0, 0, 0, 32'hFFFF_FFFF);
        probe(12'hC80, 2'b01, "R5 64-bit");
        set_state(2'd3, 0, 0, 0, 0, 1, 32'hFFFF_FFFF);
        probe(12'hC81, 2'b01, "R5 128-bit");
        set_state(2'd1, 0, 0, 0, 0, 1, 32'hFFFF_FFFE);
        probe(12'hC80, 2'b10, "R6 virt bit0 clear");
        set_state(2'd1, 0, 0, 0, 0, 1, 32'h0000_0001);
        probe(12'hC80, 2'b00, "R6 virt bit0 set");
        set_state(2'd1, 0, 0, 0, 0, 0, 32'h0);
        probe(12'hC82, 2'b00, "R6 no virt");
    endtask

    task automatic t_only32;
        set_state(2'd1, 0, 0, 0, 0, 0, 32'h0);
        probe(12'h310, 2'b00, "R7 32-bit");
        set_state(2'd2, 0, 0, 0, 0, 0, 32'h0);
        probe(12'h310, 2'b01, "R7 64-bit");
    endtask

    task automatic t_hyp32;
        set_state(2'd2, 0, 0, 0, 0, 1, 32'h0);
        probe(12'h615, 2'b01, "R8 wide virt on");
        set_state(2'd2, 0, 0, 0, 0, 0, 32'h0);
        probe(12'h615, 2'b01, "R8 wide virt off");
        probe(12'h61A, 2'b01, "R8 second reg wide");
        set_state(2'd1, 0, 0, 0, 0, 1, 32'h0);
        probe(12'h61A, 2'b00, "R8 32-bit");
    endtask

    task automatic t_unknown;
        set_state(2'd1, 1, 1, 1, 1, 0, 32'hFFFF_FFFF);
        probe(12'h7C0, 2'b01, "R9 unmapped");
        probe(12'hC23, 2'b01, "R9 past vector");
        probe(12'h004, 2'b01, "R9 past fcsr");
        probe(12'hCA0, 2'b01, "R9 past high counters");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_idle();
        t_fcsr_loose();
        t_fp();
        t_vec();
        t_ctr_lo();
        t_ctr_hi();
        t_only32();
        t_hyp32();
        t_unknown();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule